// File: doc/BRIEF.md
# Host RAM Download Command Sequencer

This block sits on a byte-wide control register bank and interprets bytes written by the host to a command port. Four single-byte commands turn into one-cycle strobes for neighbouring logic: three that switch off key-matching functions and one that asks for a reload from the hardware configuration data. A fifth command opens a download into an internal RAM. In that mode the port stops acting as a command decoder. It first takes the bytes of a start address and then writes every further byte into the RAM at an address that advances by one after each byte.

The download has no length. It ends only when the host writes a zero to a separate stop port in the same bank. After that stop, the next byte on the command port is decoded as a command again. The address width, the register offsets of the two ports and the offset field width are parameters. Elaboration checks reject an address width that is not a whole number of bytes, and reject two ports that share one offset.

Top module: `ramload_seq`

## Requirements
- R1: After reset every strobe output and `ram_we` are low, and the sequencer decodes commands.
- R2: A byte of 0x55 written to the command port (offset 5) while idle pulses `pnp_key_off_stb` for exactly one cycle, in the cycle after the write, with no other output active.
- R3: Command 0x56 pulses `key_a_off_stb` and command 0x53 pulses `key_b_off_stb`, each for one cycle in the cycle after the write.
- R4: Command 0x5A pulses `cfg_update_stb` for one cycle in the cycle after the write.
- R5: Any other command byte except 0xAA causes no output activity and leaves the sequencer idle, so a following supported command is still decoded.
- R6: Command 0xAA starts a download. The next two command-port bytes form the 16-bit start address, low byte first, and neither byte causes a RAM write.
- R7: Each later command-port byte is written to the RAM in the cycle after the write, with `ram_we` high for that one cycle, `ram_addr` equal to the current address and `ram_wdata` equal to the byte. The address then increases by one and wraps from 0xFFFF to 0x0000.
- R8: During a download, bytes equal to command codes (such as 0x55 or 0xAA) are stored as data and raise no strobe.
- R9: A write of 0x00 to the stop port (offset 6) during the address or data phase ends the download, and the next command-port byte is decoded as a command.
- R10: A nonzero write to the stop port has no effect: the download continues at the same address.
- R11: Writes to any offset other than 5 or 6 have no effect, whether idle or downloading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write in this cycle |
| wr_offset | input | OFS_W (3) | Register offset within the control bank |
| wr_data | input | 8 | Byte written by the host |
| ram_we | output | 1 | RAM write enable, one cycle per data byte |
| ram_addr | output | ADDR_W (16) | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| pnp_key_off_stb | output | 1 | One-cycle strobe: disable plug-and-play key |
| key_a_off_stb | output | 1 | One-cycle strobe: disable first vendor key |
| key_b_off_stb | output | 1 | One-cycle strobe: disable second vendor key |
| cfg_update_stb | output | 1 | One-cycle strobe: reload hardware configuration |

## Verification
All 256 byte values are sent to the idle command port. This separates the four strobe codes from the download opener and from every ignored value, and the idle cycle after each write shows that strobes last only one cycle. A download starts just below 0xFFFF and streams bytes that include command codes, which tests the address wrap and shows that data bytes are not decoded as commands. Every nonzero stop value and writes to every other offset are placed between data bytes, and the address must still advance without a gap. A stop sent during the address phase, followed by a command, shows that the sequencer returns to idle from either download phase.

// File: rtl/ramload_pkg.sv
package ramload_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2
   } seq_state_t;

   typedef enum logic [2:0] {
      CMD_NONE     = 3'd0,
      CMD_PNP_OFF  = 3'd1,
      CMD_KEYA_OFF = 3'd2,
      CMD_KEYB_OFF = 3'd3,
      CMD_CFG_UPD  = 3'd4,
      CMD_DOWNLOAD = 3'd5
   } cmd_kind_t;

   localparam logic [7:0] CODE_PNP_OFF  = 8'h55;
   localparam logic [7:0] CODE_KEYA_OFF = 8'h56;
   localparam logic [7:0] CODE_KEYB_OFF = 8'h53;
   localparam logic [7:0] CODE_CFG_UPD  = 8'h5A;
   localparam logic [7:0] CODE_DOWNLOAD = 8'hAA;
endpackage

// File: rtl/ramload_cmd_decode.sv
module ramload_cmd_decode
   import ramload_pkg::*;
(
   input  logic [7:0] cmd_byte,
   output cmd_kind_t  cmd_kind
);
   always_comb begin
      unique case (cmd_byte)
         CODE_PNP_OFF:  cmd_kind = CMD_PNP_OFF;
         CODE_KEYA_OFF: cmd_kind = CMD_KEYA_OFF;
         CODE_KEYB_OFF: cmd_kind = CMD_KEYB_OFF;
         CODE_CFG_UPD:  cmd_kind = CMD_CFG_UPD;
         CODE_DOWNLOAD: cmd_kind = CMD_DOWNLOAD;
         default:       cmd_kind = CMD_NONE;
      endcase
   end
endmodule

// File: rtl/ramload_addr_ptr.sv
module ramload_addr_ptr #(
   parameter int ADDR_W = 16,
   localparam int LANES = ADDR_W / 8,
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [IDX_W-1:0]  load_idx,
   input  logic [7:0]        load_byte,
   input  logic              inc_en,
   output logic [ADDR_W-1:0] ptr
);
   logic [ADDR_W-1:0] ptr_inc;
   logic [ADDR_W-1:0] ptr_nxt;

   assign ptr_inc = inc_en ? ptr + 1'b1 : ptr;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign ptr_nxt[g*8 +: 8] = (load_en && load_idx == IDX_W'(g)) ?
                                 load_byte : ptr_inc[g*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr <= '0;
      else        ptr <= ptr_nxt;
   end

   // R6
   load_no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_en && inc_en));
endmodule

// File: rtl/ramload_seq.sv
module ramload_seq
   import ramload_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int OFS_W    = 3,
   parameter int CMD_OFS  = 5,
   parameter int STOP_OFS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  wr_offset,
   input  logic [7:0]        wr_data,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              pnp_key_off_stb,
   output logic              key_a_off_stb,
   output logic              key_b_off_stb,
   output logic              cfg_update_stb
);
   localparam int LANES = ADDR_W / 8;
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

   if (ADDR_W % 8 != 0 || ADDR_W < 8) begin : g_bad_addr_w
      $error("ADDR_W must be a nonzero multiple of 8");
   end
   if (CMD_OFS == STOP_OFS) begin : g_bad_ofs
      $error("command and stop ports must differ");
   end
   if (CMD_OFS >= (1 << OFS_W) || STOP_OFS >= (1 << OFS_W)) begin : g_bad_ofs_w
      $error("port offset does not fit OFS_W");
   end

   seq_state_t        state;
   cmd_kind_t         cmd_kind;
   logic [IDX_W-1:0]  byte_idx;
   logic [ADDR_W-1:0] ptr;
   logic              cmd_wr, stop_wr, stop_nz_wr;
   logic              load_en, inc_en;

   assign cmd_wr     = wr_en && (wr_offset == OFS_W'(CMD_OFS));
   assign stop_wr    = wr_en && (wr_offset == OFS_W'(STOP_OFS)) && (wr_data == 8'h00);
   assign stop_nz_wr = wr_en && (wr_offset == OFS_W'(STOP_OFS)) && (wr_data != 8'h00);
   assign load_en    = cmd_wr && (state == ST_ADDR);
   assign inc_en     = cmd_wr && (state == ST_DATA);

   ramload_cmd_decode u_decode (
      .cmd_byte (wr_data),
      .cmd_kind (cmd_kind)
   );

   ramload_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .load_idx  (byte_idx),
      .load_byte (wr_data),
      .inc_en    (inc_en),
      .ptr       (ptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         byte_idx <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (cmd_wr && cmd_kind == CMD_DOWNLOAD) begin
               state    <= ST_ADDR;
               byte_idx <= '0;
            end
            ST_ADDR: if (stop_wr) begin
               state <= ST_IDLE;
            end else if (cmd_wr) begin
               if (byte_idx == IDX_W'(LANES - 1)) state <= ST_DATA;
               else                               byte_idx <= byte_idx + 1'b1;
            end
            ST_DATA: if (stop_wr) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_we          <= 1'b0;
         ram_addr        <= '0;
         ram_wdata       <= '0;
         pnp_key_off_stb <= 1'b0;
         key_a_off_stb   <= 1'b0;
         key_b_off_stb   <= 1'b0;
         cfg_update_stb  <= 1'b0;
      end else begin
         ram_we <= inc_en;
         if (inc_en) begin
            ram_addr  <= ptr;
            ram_wdata <= wr_data;
         end
         pnp_key_off_stb <= cmd_wr && state == ST_IDLE && cmd_kind == CMD_PNP_OFF;
         key_a_off_stb   <= cmd_wr && state == ST_IDLE && cmd_kind == CMD_KEYA_OFF;
         key_b_off_stb   <= cmd_wr && state == ST_IDLE && cmd_kind == CMD_KEYB_OFF;
         cfg_update_stb  <= cmd_wr && state == ST_IDLE && cmd_kind == CMD_CFG_UPD;
      end
   end

   // R2
   one_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_we, pnp_key_off_stb, key_a_off_stb, key_b_off_stb, cfg_update_stb}));

   // R8
   stb_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pnp_key_off_stb || key_a_off_stb || key_b_off_stb || cfg_update_stb)
      |-> ($past(state) == ST_IDLE && $past(cmd_wr)));

   // R7
   addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (ptr == ram_addr + 1'b1));

   // R7
   we_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ($past(state) == ST_DATA && $past(cmd_wr)));

   // R9
   stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_wr |=> (state == ST_IDLE));

   // R10
   stop_nz_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_nz_wr |=> (state == $past(state) && ptr == $past(ptr)));
endmodule

// File: tb/ramload_seq_tb.sv
module ramload_seq_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_offset = '0;
   logic [7:0]  wr_data = '0;
   logic        ram_we;
   logic [15:0] ram_addr;
   logic [7:0]  ram_wdata;
   logic        pnp_key_off_stb, key_a_off_stb, key_b_off_stb, cfg_update_stb;

   int n_vec = 0;
   int n_bad = 0;
   logic [15:0] cur;

   always #(CLK_PERIOD/2) clk = ~clk;

   ramload_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_offset(wr_offset), .wr_data(wr_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .pnp_key_off_stb(pnp_key_off_stb), .key_a_off_stb(key_a_off_stb),
      .key_b_off_stb(key_b_off_stb), .cfg_update_stb(cfg_update_stb)
   );

   // vector order {ram_we, pnp, key_a, key_b, cfg}
   task automatic check(input string tag, input logic [4:0] exp,
                        input logic [15:0] ea, input logic [7:0] ed);
      logic [4:0] got;
      got = {ram_we, pnp_key_off_stb, key_a_off_stb, key_b_off_stb, cfg_update_stb};
      n_vec++;
      if (got !== exp || (exp[4] && (ram_addr !== ea || ram_wdata !== ed))) begin
         n_bad++;
         $display("FAIL %s: outs=%b addr=%h data=%h expected outs=%b addr=%h data=%h",
                  tag, got, ram_addr, ram_wdata, exp, ea, ed);
      end
   endtask

   // drive one write, sample just after the capturing edge
   task automatic wr(input logic [2:0] ofs, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_offset = ofs; wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic idle();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [4:0] exp_cmd(input logic [7:0] b);
      case (b)
         8'h55:   return 5'b01000;
         8'h56:   return 5'b00100;
         8'h53:   return 5'b00010;
         8'h5A:   return 5'b00001;
         default: return 5'b00000;
      endcase
   endfunction

   task automatic data(input logic [7:0] d, input string tag);
      wr(3'd5, d);
      check(tag, 5'b10000, cur, d);
      cur = cur + 16'd1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset", 5'b00000, '0, '0);
      @(negedge clk);
      rst_n = 1'b1;
      idle();
      check("R1 after reset", 5'b00000, '0, '0);

      // sweep of every command byte in idle
      for (int b = 0; b < 256; b++) begin
         wr(3'd5, 8'(b));
         if (b == 8'h55)       check("R2 pnp", exp_cmd(8'(b)), '0, '0);
         else if (b == 8'h56 || b == 8'h53) check("R3 key", exp_cmd(8'(b)), '0, '0);
         else if (b == 8'h5A)  check("R4 cfg", exp_cmd(8'(b)), '0, '0);
         else                  check("R5 ignored", exp_cmd(8'(b)), '0, '0);
         idle();
         check("R2 one-cycle strobe", 5'b00000, '0, '0);
         if (b == 8'hAA) begin
            wr(3'd6, 8'h00);
            check("R9 stop opened download", 5'b00000, '0, '0);
         end
      end
      wr(3'd5, 8'h55);
      check("R5 still idle after sweep", 5'b01000, '0, '0);

      // R11: other offsets ignored when idle
      for (int o = 0; o < 8; o++) begin
         if (o != 5) begin
            wr(3'(o), 8'h55);
            check("R11 idle offset", 5'b00000, '0, '0);
         end
      end

      // R6: download near top of address space
      wr(3'd5, 8'hAA);
      check("R6 open", 5'b00000, '0, '0);
      wr(3'd5, 8'hFE);
      check("R6 low byte", 5'b00000, '0, '0);
      wr(3'd5, 8'hFF);
      check("R6 high byte", 5'b00000, '0, '0);
      cur = 16'hFFFE;
      data(8'h11, "R7 first data");
      data(8'h55, "R8 code as data");
      data(8'hAA, "R8 download code as data (R7 wrap)");
      data(8'h5A, "R8 cfg code as data");
      idle();
      check("R7 one-cycle we", 5'b00000, '0, '0);

      // R10: every nonzero stop value is ignored
      for (int v = 1; v < 256; v++) begin
         wr(3'd6, 8'(v));
         check("R10 nonzero stop", 5'b00000, '0, '0);
         data(8'(v ^ 8'h3C), "R10 stream continues");
      end

      // R11: other offsets during download
      for (int o = 0; o < 8; o++) begin
         if (o != 5 && o != 6) begin
            wr(3'(o), 8'h00);
            check("R11 download offset", 5'b00000, '0, '0);
            data(8'(o), "R11 stream continues");
         end
      end

      // R9: stop then command decoded
      wr(3'd6, 8'h00);
      check("R9 stop", 5'b00000, '0, '0);
      wr(3'd5, 8'h56);
      check("R9 command after stop", 5'b00100, '0, '0);

      // R9: stop during address phase
      wr(3'd5, 8'hAA);
      wr(3'd5, 8'h34);
      wr(3'd6, 8'h00);
      check("R9 stop in address phase", 5'b00000, '0, '0);
      wr(3'd5, 8'h53);
      check("R9 command after addr stop", 5'b00010, '0, '0);

      // fresh download: new address fully reloaded
      wr(3'd5, 8'hAA);
      wr(3'd5, 8'h00);
      wr(3'd5, 8'h12);
      cur = 16'h1200;
      data(8'h00, "R7 zero data byte");
      data(8'hC3, "R7 second address");
      wr(3'd6, 8'h00);
      wr(3'd5, 8'h5A);
      check("R4 cfg after download", 5'b00001, '0, '0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule